// File: doc/BRIEF.md
# Programmable-Priority DMA Request Arbiter

This block picks which of several DMA channels may use the shared transfer path next. Every channel has a request line and a two-bit priority field that software can rewrite at any time. When no grant is outstanding, the arbiter looks at the channels that are requesting and finds the highest priority level among them. Among the requesters at that level, the channel with the smallest index wins.

The winner is registered as a one-hot grant together with its binary index. The grant is held until the granted channel pulses `done_i` to show that its single item has moved. The edge that sees `done_i` clears the grant. The next idle cycle then runs a fresh arbitration, using the request and priority values present in that cycle. Priority fields are only looked at while the arbiter is idle, so rewriting one during a transfer changes nothing until the next arbitration.

Top module: `dma_prio_arbiter`

## Requirements
- R1: While no channel requests, no grant is issued: `grant_o` stays all zero and `grant_idx_o` is 0.
- R2: Channel c's priority is `prio_i[2c+1:2c]`, with 2'b00 low, 2'b01 medium, 2'b10 high and 2'b11 very high. The requesting channel with the largest level wins.
- R3: When several requesting channels share the largest level, the one with the lowest index wins.
- R4: Requests and priorities seen in an idle cycle produce the grant at the next rising edge. `grant_o` is then one-hot, and `grant_idx_o` holds the position of its set bit.
- R5: Once issued, a grant stays unchanged until `done_i` is seen, whatever happens on `req_i` or `prio_i` in the meantime.
- R6: The edge that samples `done_i` high while a grant is held clears the grant. The following idle cycle arbitrates again. `done_i` has no effect while no grant is held.
- R7: A channel whose request falls before the arbiter's idle cycle is never granted for that request.
- R8: A priority change made while a grant is held takes effect at the next arbitration and not before.
- R9: After reset is asserted, `grant_o` is zero and `grant_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CH | Per-channel request lines |
| prio_i | input | 2*NUM_CH | Packed two-bit priority per channel |
| done_i | input | 1 | Granted channel's item-finished strobe |
| grant_o | output | NUM_CH | One-hot grant, zero when idle |
| grant_idx_o | output | IDX_W | Index of the granted channel |

## Verification
Two functions can fall in the same cycle. A held grant can be released by `done_i` while other channels are raising requests or rewriting their priorities. The bench provokes this by holding a grant for several cycles while a competitor moves to a higher level, then asserting `done_i`. It judges the result by checking three things: the grant stays put until `done_i`, it drops to zero on the release edge, and the next grant goes to the winner computed from the values in the idle cycle. It does not go to the winner under the priorities that held when the transfer started.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W  = 2;
  localparam int NUM_LVL = 1 << PRIO_W;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  output logic [NUM_CH-1:0]        win_o
);
  logic [NUM_LVL-1:0][NUM_CH-1:0] at_lvl;
  logic [NUM_CH-1:0]              cand;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    prio_t p;
    assign p = prio_i[c*PRIO_W +: PRIO_W];
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign at_lvl[l][c] = req_i[c] && (p == prio_t'(l));
    end
  end

  // highest occupied level first
  always_comb begin
    cand = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (cand == '0) cand = at_lvl[l];
    end
  end

  // isolate lowest set bit: lowest index wins ties
  assign win_o = cand & (~cand + NUM_CH'(1));
endmodule

// File: rtl/dma_arb_enc.sv
module dma_arb_enc #(
  parameter int NUM_CH = 6,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] oh_i,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (oh_i[c]) idx_o = idx_o | IDX_W'(c);
    end
  end
endmodule

// File: rtl/dma_arb_hold.sv
module dma_arb_hold #(
  parameter int NUM_CH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] win_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] grant_o
);
  logic busy;
  assign busy = |grant_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     grant_o <= '0;
    else if (!busy)  grant_o <= win_i;
    else if (done_i) grant_o <= '0;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));                                          // R4
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_i) |=> $stable(grant_o));                     // R5
  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && done_i) |=> (grant_o == '0));                       // R6
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 6,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        req_i,
  input  logic [NUM_CH*PRIO_W-1:0] prio_i,
  input  logic                     done_i,
  output logic [NUM_CH-1:0]        grant_o,
  output logic [IDX_W-1:0]         grant_idx_o
);
  logic [NUM_CH-1:0] win;

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i (req_i),
    .prio_i(prio_i),
    .win_o (win)
  );

  dma_arb_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win),
    .done_i (done_i),
    .grant_o(grant_o)
  );

  dma_arb_enc #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_enc (
    .oh_i (grant_o),
    .idx_o(grant_idx_o)
  );

  AST_NO_REQ_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0 && req_i == '0) |=> (grant_o == '0));         // R1
  AST_GRANT_HAD_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0) |=> (grant_o == '0 || (grant_o & $past(req_i)) != '0)); // R7
  AST_IDX_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> grant_o[grant_idx_o]);                   // R4
  AST_REQ_GETS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o == '0 && req_i != '0) |=> (grant_o != '0));         // R2
endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
  localparam int NUM_CH = 6;
  localparam int IDX_W  = 3;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic [NUM_CH-1:0]      req_i = '0;
  logic [1:0]             prio_arr [NUM_CH];
  logic [NUM_CH*2-1:0]    prio_i;
  logic                   done_i = 1'b0;
  logic [NUM_CH-1:0]      grant_o;
  logic [IDX_W-1:0]       grant_idx_o;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int c = 0; c < NUM_CH; c++) prio_i[2*c +: 2] = prio_arr[c];

  dma_prio_arbiter #(.NUM_CH(NUM_CH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .prio_i(prio_i),
    .done_i(done_i), .grant_o(grant_o), .grant_idx_o(grant_idx_o));

  // independent reference: scan levels top-down, channels bottom-up
  function automatic int model_pick(input logic [NUM_CH-1:0] r);
    for (int l = 3; l >= 0; l--)
      for (int c = 0; c < NUM_CH; c++)
        if (r[c] && prio_arr[c] == 2'(l)) return c;
    return -1;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input int exp);
    int act;
    logic [NUM_CH-1:0] exp_oh;
    exp_oh = (exp < 0) ? '0 : NUM_CH'(1) << exp;
    act = (grant_o == '0) ? -1 : int'(grant_idx_o);
    n_chk++;
    if (grant_o !== exp_oh || (exp >= 0 && act != exp) || (exp < 0 && grant_idx_o !== '0)) begin
      n_fail++;
      $display("FAIL %s: grant=%b idx=%0d expected grant=%b idx=%0d", tag, grant_o, act, exp_oh, exp);
    end
  endtask

  task automatic set_prio(input logic [1:0] p0, p1, p2, p3, p4, p5);
    prio_arr[0] = p0; prio_arr[1] = p1; prio_arr[2] = p2;
    prio_arr[3] = p3; prio_arr[4] = p4; prio_arr[5] = p5;
  endtask

  task automatic release_grant(input string tag);
    done_i = 1'b1; tick(); done_i = 1'b0;
    chk({tag, " R6 release"}, -1);
  endtask

  task automatic t_reset();
    chk("R9 reset", -1);
    rst_ni = 1'b1; tick(); tick();
    chk("R1 idle no request", -1);
    done_i = 1'b1; tick(); done_i = 1'b0;
    chk("R6 done while idle", -1);
  endtask

  task automatic t_level();
    set_prio(2'b00, 2'b01, 2'b10, 2'b00, 2'b11, 2'b00);
    req_i = 6'b010110; tick();
    chk("R2 very high wins", model_pick(6'b010110));
    req_i = '0; release_grant("R2");
    req_i = 6'b000110; tick();
    chk("R2 high beats medium", 2);
    req_i = '0; release_grant("R2b");
  endtask

  task automatic t_tie();
    set_prio(2'b01, 2'b00, 2'b00, 2'b10, 2'b00, 2'b10);
    req_i = 6'b101001; tick();
    chk("R3 tie lowest index", 3);
    req_i = '0; release_grant("R3");
    set_prio(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    req_i = 6'b111111; tick();
    chk("R3 all low picks ch0", 0);
    req_i = '0; release_grant("R3b");
  endtask

  task automatic t_hold_and_prio();
    set_prio(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b11);
    req_i = 6'b000100; tick();
    chk("R4 grant one edge after idle", 2);
    req_i = 6'b100101;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R5 hold against higher requester", 2);
    end
    prio_arr[0] = 2'b11; prio_arr[2] = 2'b00;
    tick(); chk("R8 priority change ignored mid-grant", 2);
    req_i = 6'b100001;
    release_grant("R8");
    tick(); chk("R8 new priority used at rearbitration", 0);
    req_i = 6'b100000;
    release_grant("R8b");
    tick(); chk("R6 rearbitration after release", 5);
    req_i = '0; release_grant("R6c");
  endtask

  task automatic t_drop();
    set_prio(2'b00, 2'b11, 2'b00, 2'b00, 2'b01, 2'b00);
    req_i = 6'b010000; tick();
    chk("R4 lone requester", 4);
    req_i = 6'b010010; tick();
    req_i = 6'b010000; tick();
    chk("R7 hold while ch1 pulses", 4);
    req_i = '0; release_grant("R7");
    tick(); chk("R7 dropped request not granted", -1);
    tick(); chk("R1 stays idle", -1);
  endtask

  initial begin
    set_prio(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
    #7;
    t_reset();
    t_level();
    t_tie();
    t_hold_and_prio();
    t_drop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule